// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block controls a set of switchable power domains. Software writes a target power state for each domain into a control word. For every domain whose target differs from its present state, the block runs a strictly ordered handshake. To turn a domain off, it first isolates the domain's bus interface with an idle request and only then opens the power switch. To turn a domain on, it first closes the switch and only then releases the idle request.

Only one domain sequence runs at a time. When one write selects several domains, they are handled one after another, lowest index first. Every wait phase has a microsecond-based timeout. A timeout aborts the sequence and sets a per-domain error flag. The acknowledge, idle and power-status inputs pass through two-flop synchronisers before the sequencer uses them. Each domain group has a programmable settling delay for the switch, one value for turning off and one for turning on, counted in clock cycles.

Top module: `pds_seq_top`

## Requirements
- R1: A write to the control word (word address 0) changes target bit n (n < NDOM) only when bit n+16 of the same write is 1. Bits whose enable is 0 keep their value. Reading word 0 returns the target bits in the low half and zero in the high half.
- R2: Encoding. A target bit of 1 requests the domain off and 0 requests it on. `pwr_off` = 1 opens the power switch. A `pwr_st` of 1 means the domain is unpowered and 0 means it is powered.
- R3: A power-down raises `idle_req`, waits for the synchronised acknowledge to be 1, then for the synchronised idle indication to be 1, and only then raises `pwr_off`. It then waits for status to show the domain off.
- R4: A power-up lowers `pwr_off` and waits for status to show the domain powered. Only then does it lower `idle_req`, and it finishes once acknowledge and then idle have both returned to 0.
- R5: Each wait phase ends with an abort after TIMEOUT_US microseconds of TICKS_PER_US clocks. An abort sets that domain's error bit (`dom_err`, and bit 16+n of word 1), leaves its outputs as they are, and ends the request with `done`. An errored domain is skipped until a control write with its enable bit set clears the error; that write retries the domain.
- R6: For a domain without a status input (HAS_STAT bit 0), bit n of word 1 reports the synchronised idle indication in place of the status. Its power phase does not wait on `pwr_st`.
- R7: A domain without a power switch (HAS_PWR bit 0) performs only the idle handshake. Its `pwr_off` stays 0.
- R8: Each group g of two has a power-down delay at word 2+2g and a power-up delay at the following word 3+2g. Both reset to DLY_RST (24). After `pwr_off` changes, the sequencer waits that many cycles plus one before it samples status.
- R9: An accepted control write that leaves no domain needing a change produces a one-cycle `done` pulse within two cycles, with no change on `idle_req` or `pwr_off`.
- R10: `busy` is 1 from an accepted control write until its `done`. Control writes while busy are ignored. Domains selected together are sequenced one at a time, lowest index first.
- R11: After reset, all domains are on and all idle requests are released. `busy`, `done` and all error bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Write data; control word uses bits 31:16 as per-bit enables |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read data (combinational) |
| idle_ack | input | NDOM | Per-domain acknowledge of the idle request (asynchronous) |
| idle_st | input | NDOM | Per-domain idle indication (asynchronous) |
| pwr_st | input | NDOM | Per-domain power status, 1 = off (asynchronous) |
| idle_req | output | NDOM | Per-domain idle request to the bus interface unit |
| pwr_off | output | NDOM | Per-domain power-switch control, 1 = off |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request has finished or aborted |
| dom_err | output | NDOM | Sticky per-domain timeout flags |

## Verification
Two events can meet on the same clock edge: a control write and the sequencer's own progress on an earlier request. Software could write while the sequencer is still working through a multi-domain request. The bench provokes this by issuing a second, conflicting control write right after a two-domain write, while `busy` is high. It then judges the result at the ports in three ways. The target word read back must still hold only the first request. The third domain must never see `idle_req`. The second domain's idle request must rise only after the first domain's switch has opened.

// File: rtl/pds_pkg.sv
package pds_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ_ACK,   // wait acknowledge high
        S_REQ_IDL,   // wait idle high
        S_DLY,       // switch settling delay
        S_PWR,       // wait power status
        S_REL_ACK,   // wait acknowledge low
        S_REL_IDL    // wait idle low
    } seq_st_e;

    // Register word addresses
    localparam logic [2:0] A_CTRL     = 3'd0;
    localparam logic [2:0] A_STAT     = 3'd1;
    localparam int         A_DLY_BASE = 2;   // group g: down at base+2g, up at base+2g+1
    localparam int         N_GRP      = 2;

    // Lowest set bit, 16-bit search
    function automatic logic [3:0] first_one(input logic [15:0] v);
        first_one = 4'd0;
        for (int i = 15; i >= 0; i--) begin
            if (v[i]) first_one = 4'(i);
        end
    endfunction

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int TICKS_PER_US = 24,
    parameter int TIMEOUT_US   = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam int US_W  = $clog2(TIMEOUT_US + 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;

    assign expired = (us_q == US_W'(TIMEOUT_US));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (!expired) begin
            if (pre_q == PRE_W'(TICKS_PER_US - 1)) begin
                pre_q <= '0;
                us_q  <= us_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pds_regbank.sv
module pds_regbank
    import pds_pkg::*;
#(
    parameter int NDOM    = 4,
    parameter int DLY_W   = 16,
    parameter int DLY_RST = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_addr,
    input  logic [31:0]                   wr_data,
    input  logic                          ctrl_ok,
    input  logic [31:0]                   stat_word,
    input  logic [2:0]                    rd_addr,
    output logic [31:0]                   rd_data,
    output logic [NDOM-1:0]               target,
    output logic [N_GRP-1:0][DLY_W-1:0]   dly_dn,
    output logic [N_GRP-1:0][DLY_W-1:0]   dly_up
);
    wire unused_wr_bits = ^wr_data;

    // Masked control write: enable for bit n sits at n+16
    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
        end else if (wr_en && wr_addr == A_CTRL && ctrl_ok) begin
            for (int n = 0; n < NDOM; n++) begin
                if (wr_data[n+16]) target[n] <= wr_data[n];
            end
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [DLY_W-1:0] dn_q, up_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                dn_q <= DLY_W'(DLY_RST);
                up_q <= DLY_W'(DLY_RST);
            end else if (wr_en) begin
                if (wr_addr == 3'(A_DLY_BASE + 2*g))     dn_q <= wr_data[DLY_W-1:0];
                if (wr_addr == 3'(A_DLY_BASE + 2*g + 1)) up_q <= wr_data[DLY_W-1:0];
            end
        end
        assign dly_dn[g] = dn_q;
        assign dly_up[g] = up_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) rd_data = 32'(target);
        if (rd_addr == A_STAT) rd_data = stat_word;
        for (int g = 0; g < N_GRP; g++) begin
            if (rd_addr == 3'(A_DLY_BASE + 2*g))     rd_data = 32'(dly_dn[g]);
            if (rd_addr == 3'(A_DLY_BASE + 2*g + 1)) rd_data = 32'(dly_up[g]);
        end
    end
endmodule

// File: rtl/pds_seq_top.sv
module pds_seq_top
    import pds_pkg::*;
#(
    parameter int              NDOM         = 4,
    parameter logic [NDOM-1:0] HAS_PWR      = '1,
    parameter logic [NDOM-1:0] HAS_STAT     = '1,
    parameter logic [NDOM-1:0] GROUP        = '0,
    parameter int              TICKS_PER_US = 24,
    parameter int              TIMEOUT_US   = 10000,
    parameter int              DLY_W        = 16,
    parameter int              DLY_RST      = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [2:0]      rd_addr,
    output logic [31:0]     rd_data,
    input  logic [NDOM-1:0] idle_ack,
    input  logic [NDOM-1:0] idle_st,
    input  logic [NDOM-1:0] pwr_st,
    output logic [NDOM-1:0] idle_req,
    output logic [NDOM-1:0] pwr_off,
    output logic            busy,
    output logic            done,
    output logic [NDOM-1:0] dom_err
);
    localparam int IDX_W = (NDOM > 1) ? $clog2(NDOM) : 1;

    logic [NDOM-1:0] ack_s, idl_s, st_s;
    logic [NDOM-1:0] target, state_q, err_q, req_q, off_q, pend, rpt;
    logic [N_GRP-1:0][DLY_W-1:0] dly_dn, dly_up;
    logic [DLY_W-1:0] dly_q;
    logic [IDX_W-1:0] cur_q, nxt_idx;
    logic             dir_q, armed_q, done_q, accept, restart, expired;
    logic             fin, abort, ack_c, idl_c, st_c, cur_pwr, cur_stat;
    seq_st_e          st_q, st_d;

    pds_sync #(.W(3*NDOM)) u_sync (
        .clk (clk), .rst (rst),
        .d   ({idle_ack, idle_st, pwr_st}),
        .q   ({ack_s, idl_s, st_s})
    );

    assign pend    = (target ^ state_q) & ~err_q;
    assign busy    = (st_q != S_IDLE) || (|pend) || armed_q;
    assign accept  = wr_en && (wr_addr == A_CTRL) && !busy;
    assign rpt     = (HAS_STAT & st_s) | (~HAS_STAT & idl_s);
    assign nxt_idx = IDX_W'(first_one(16'(pend)));

    pds_regbank #(.NDOM(NDOM), .DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_regs (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .ctrl_ok (!busy),
        .stat_word ({16'(err_q), 16'(rpt)}),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .target (target), .dly_dn (dly_dn), .dly_up (dly_up)
    );

    pds_timer #(.TICKS_PER_US(TICKS_PER_US), .TIMEOUT_US(TIMEOUT_US)) u_tmr (
        .clk (clk), .rst (rst), .restart (restart), .expired (expired)
    );

    assign ack_c    = ack_s[cur_q];
    assign idl_c    = idl_s[cur_q];
    assign st_c     = st_s[cur_q];
    assign cur_pwr  = HAS_PWR[cur_q];
    assign cur_stat = HAS_STAT[cur_q];

    // Phase progression
    always_comb begin
        st_d  = st_q;
        fin   = 1'b0;
        abort = 1'b0;
        unique case (st_q)
            S_IDLE: if (|pend)
                st_d = target[nxt_idx] ? S_REQ_ACK : (HAS_PWR[nxt_idx] ? S_DLY : S_REL_ACK);
            S_REQ_ACK: if (ack_c) st_d = S_REQ_IDL; else abort = expired;
            S_REQ_IDL: if (idl_c) begin
                if (cur_pwr) st_d = S_DLY; else fin = 1'b1;
            end else abort = expired;
            S_DLY: if (dly_q == '0) st_d = S_PWR;
            S_PWR: if (!cur_stat || (st_c == dir_q)) begin
                if (dir_q) fin = 1'b1; else st_d = S_REL_ACK;
            end else abort = expired;
            S_REL_ACK: if (!ack_c) st_d = S_REL_IDL; else abort = expired;
            S_REL_IDL: if (!idl_c) fin = 1'b1; else abort = expired;
            default: st_d = S_IDLE;
        endcase
        if (fin || abort) st_d = S_IDLE;
    end

    assign restart = (st_d != st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            cur_q   <= '0;
            dir_q   <= 1'b0;
            state_q <= '0;
            err_q   <= '0;
            req_q   <= '0;
            off_q   <= '0;
            dly_q   <= '0;
            armed_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= 1'b0;
            if (accept) begin
                armed_q <= 1'b1;
                err_q   <= err_q & ~wr_data[NDOM+15:16];
            end
            unique case (st_q)
                S_IDLE: begin
                    if (|pend) begin
                        cur_q <= nxt_idx;
                        dir_q <= target[nxt_idx];
                        if (target[nxt_idx]) begin
                            req_q[nxt_idx] <= 1'b1;
                        end else if (HAS_PWR[nxt_idx]) begin
                            off_q[nxt_idx] <= 1'b0;
                            dly_q          <= dly_up[GROUP[nxt_idx]];
                        end else begin
                            req_q[nxt_idx] <= 1'b0;
                        end
                    end else if (armed_q) begin
                        done_q  <= 1'b1;
                        armed_q <= 1'b0;
                    end
                end
                S_REQ_IDL: if (idl_c && cur_pwr) begin
                    off_q[cur_q] <= 1'b1;
                    dly_q        <= dly_dn[GROUP[cur_q]];
                end
                S_DLY: if (dly_q != '0) dly_q <= dly_q - 1'b1;
                S_PWR: if ((!cur_stat || (st_c == dir_q)) && !dir_q) req_q[cur_q] <= 1'b0;
                default: ;
            endcase
            if (fin)   state_q[cur_q] <= dir_q;
            if (abort) err_q[cur_q]   <= 1'b1;
        end
    end

    assign idle_req = req_q;
    assign pwr_off  = off_q;
    assign done     = done_q;
    assign dom_err  = err_q;
endmodule

// File: rtl/pds_seq_chk.sv
module pds_seq_chk #(
    parameter int NDOM = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [NDOM-1:0] idle_req,
    input logic [NDOM-1:0] pwr_off,
    input logic            busy,
    input logic            done
);
    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        AST_DOWN_GATED: assert property (@(posedge clk) disable iff (rst)
            $rose(pwr_off[i]) |-> idle_req[i]) else $error("switch opened without idle request"); // R3
        AST_UP_GATED: assert property (@(posedge clk) disable iff (rst)
            $fell(idle_req[i]) |-> !pwr_off[i]) else $error("idle released while unpowered"); // R4
    end

    AST_SINGLE_MOVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0((idle_req ^ $past(idle_req)) | (pwr_off ^ $past(pwr_off))))
        else $error("two domains moved at once"); // R10
    AST_MOVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ((idle_req != $past(idle_req)) || (pwr_off != $past(pwr_off))) |-> $past(busy))
        else $error("output moved while not busy"); // R10
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done while busy"); // R9
endmodule

bind pds_seq_top pds_seq_chk #(.NDOM(NDOM)) u_chk (
    .clk (clk), .rst (rst), .idle_req (idle_req), .pwr_off (pwr_off),
    .busy (busy), .done (done)
);

// File: tb/sim_pds_seq_top.sv
`timescale 1ns/1ps
module sim_pds_seq_top;
    localparam int NDOM = 4;
    localparam logic [NDOM-1:0] HAS_PWR  = 4'b0111;
    localparam logic [NDOM-1:0] HAS_STAT = 4'b0011;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [NDOM-1:0] idle_ack, idle_st, pwr_st, idle_req, pwr_off, dom_err;
    logic busy, done;
    logic [NDOM-1:0] stuck_ack = '0;
    logic [NDOM-1:0] st_kill = 4'b0100;

    int n_chk = 0, n_bad = 0, cyc = 0, done_cyc = 0;
    int last_req_rise [NDOM];
    int last_off_rise [NDOM];
    logic bad_dn = 1'b0, bad_up = 1'b0, nopwr_moved = 1'b0;

    always #10 clk = ~clk;

    pds_seq_top #(
        .NDOM(NDOM), .HAS_PWR(HAS_PWR), .HAS_STAT(HAS_STAT), .GROUP(4'b1010),
        .TICKS_PER_US(2), .TIMEOUT_US(5), .DLY_W(16), .DLY_RST(24)
    ) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .idle_ack(idle_ack), .idle_st(idle_st),
        .pwr_st(pwr_st), .idle_req(idle_req), .pwr_off(pwr_off), .busy(busy),
        .done(done), .dom_err(dom_err)
    );

    // Domain model: fixed response latencies
    logic [NDOM-1:0] a1, a2, a3, i1, i2, s1, s2, s3, s4;
    always_ff @(posedge clk) begin
        if (rst) begin
            {a1, a2, a3, i1, i2, s1, s2, s3, s4} <= '0;
        end else begin
            a1 <= idle_req; a2 <= a1; a3 <= a2;
            i1 <= idle_ack; i2 <= i1;
            s1 <= pwr_off; s2 <= s1; s3 <= s2; s4 <= s3;
        end
    end
    assign idle_ack = a3 & ~stuck_ack;
    assign idle_st  = i2;
    assign pwr_st   = s4 & ~st_kill;

    always @(posedge clk) cyc <= cyc + 1;

    // Port monitor
    logic [NDOM-1:0] req_p = '0, off_p = '0;
    always @(negedge clk) begin
        for (int d = 0; d < NDOM; d++) begin
            if (idle_req[d] && !req_p[d]) last_req_rise[d] = cyc;
            if (pwr_off[d] && !off_p[d]) begin
                last_off_rise[d] = cyc;
                if (!idle_st[d]) bad_dn = 1'b1;
            end
            if (!idle_req[d] && req_p[d] && HAS_STAT[d] && pwr_st[d]) bad_up = 1'b1;
            if (!HAS_PWR[d] && pwr_off[d]) nopwr_moved = 1'b1;
        end
        req_p = idle_req;
        off_p = pwr_off;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        done_cyc = cyc;
        check("done seen", 32'(done), 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R11 idle_req", 32'(idle_req), 0);
        check("R11 pwr_off", 32'(pwr_off), 0);
        check("R11 busy", 32'(busy), 0);
        check("R11 dom_err", 32'(dom_err), 0);
        rd(3'd0, v); check("R11 target", v, 0);
        rd(3'd1, v); check("R11 status word", v, 0);
        rd(3'd2, v); check("R8 down delay reset", v, 24);
        rd(3'd5, v); check("R8 up delay reset", v, 24);
    endtask

    task automatic t_mask;
        logic [31:0] v; int n;
        wr(3'd0, 32'h0002_000D);
        wait_done(n);
        check("R9 no-op done latency", 32'(n <= 2), 1);
        rd(3'd0, v); check("R1 unenabled bits kept", v, 0);
        check("R9 no output change", 32'({idle_req, pwr_off}), 0);
        wr(3'd0, 32'h0000_000F);
        wait_done(n);
        rd(3'd0, v); check("R1 zero enables", v, 0);
    endtask

    task automatic t_down_up0;
        logic [31:0] v; int n;
        wr(3'd0, 32'h0001_0001);
        wait_done(n);
        check("R2 pwr_off high for off", 32'(pwr_off), 32'h1);
        check("R3 idle_req held", 32'(idle_req), 32'h1);
        check("R3 order down", 32'(bad_dn), 0);
        rd(3'd1, v); check("R2 status reports off", v, 32'h1);
        wr(3'd0, 32'h0001_0000);
        wait_done(n);
        check("R4 switch closed", 32'(pwr_off), 0);
        check("R4 idle released", 32'(idle_req), 0);
        check("R4 order up", 32'(bad_up), 0);
        rd(3'd1, v); check("R4 status reports on", v, 0);
    endtask

    task automatic t_nostat;
        logic [31:0] v; int n;
        wr(3'd0, 32'h0004_0004);
        wait_done(n);
        check("R6 switch opened", 32'(pwr_off), 32'h4);
        rd(3'd1, v); check("R6 idle-derived off", v, 32'h4);
        wr(3'd0, 32'h0004_0000);
        wait_done(n);
        rd(3'd1, v); check("R6 idle-derived on", v, 0);
    endtask

    task automatic t_idleonly;
        logic [31:0] v; int n;
        wr(3'd0, 32'h0008_0008);
        wait_done(n);
        check("R7 idle request only", 32'({idle_req, pwr_off}), 32'h80);
        rd(3'd1, v); check("R7 reported off", v, 32'h8);
        wr(3'd0, 32'h0008_0000);
        wait_done(n);
        check("R7 released", 32'(idle_req), 0);
        check("R7 switch never moved", 32'(nopwr_moved), 0);
    endtask

    task automatic t_multi;
        logic [31:0] v; int n;
        wr(3'd0, 32'h0003_0003);
        check("R10 busy after write", 32'(busy), 1);
        wr(3'd0, 32'h0004_0004);
        wait_done(n);
        rd(3'd0, v); check("R10 write while busy ignored", v, 32'h3);
        check("R10 both off", 32'({idle_req, pwr_off}), 32'h33);
        check("R10 lowest first, one at a time",
              32'(last_req_rise[1] > last_off_rise[0]), 1);
        wr(3'd0, 32'h0003_0000);
        wait_done(n);
        check("R10 both back on", 32'({idle_req, pwr_off}), 0);
    endtask

    task automatic t_timeout;
        logic [31:0] v; int n;
        stuck_ack = 4'b0010;
        wr(3'd0, 32'h0002_0002);
        wait_done(n);
        check("R5 error flag", 32'(dom_err), 32'h2);
        rd(3'd1, v); check("R5 error in status word", v[31:16], 32'h2);
        check("R5 switch untouched", 32'(pwr_off), 0);
        check("R5 bound honoured", 32'(n >= 10 && n <= 16), 1);
        stuck_ack = '0;
        wr(3'd0, 32'h0002_0002);
        wait_done(n);
        check("R5 retry clears error", 32'(dom_err), 0);
        check("R5 retry completes", 32'(pwr_off), 32'h2);
        wr(3'd0, 32'h0002_0000);
        wait_done(n);
        check("R5 domain back on", 32'(pwr_off), 0);
    endtask

    task automatic t_delay;
        logic [31:0] v; int n, la, lb;
        wr(3'd2, 32'd8);
        wr(3'd0, 32'h0001_0001);
        wait_done(n);
        la = done_cyc - last_off_rise[0];
        wr(3'd0, 32'h0001_0000);
        wait_done(n);
        wr(3'd2, 32'd15);
        wr(3'd0, 32'h0001_0001);
        wait_done(n);
        lb = done_cyc - last_off_rise[0];
        check("R8 down delay adds cycles", 32'(lb - la), 32'd7);
        rd(3'd3, v); check("R8 up delay at next word", v, 24);
        wr(3'd0, 32'h0001_0000);
        wait_done(n);
        check("R8 domain back on", 32'(pwr_off), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask();
        t_down_up0();
        t_nostat();
        t_idleonly();
        t_multi();
        t_timeout();
        t_delay();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule